// File: doc/BRIEF.md
# Single-Step Halt and Address Display Unit

This unit sits beside a small 8-bit microcontroller core and lets a debugger advance the program one instruction per request. While step mode is enabled, the unit lets the core finish the instruction in progress. Then it withholds the core's run permission and shows the 12-bit address of the next instruction on the shared I/O pins. The low byte of the address goes on the data bus and the high nibble goes on the low four lines of port 2. An instruction may take one or two machine cycles. The unit tracks the cycles itself, so a halt never falls between the two cycles of a longer instruction.

A step request comes from an asynchronous button or debugger line. It is synchronized and reduced to its rising edge, so a request held high releases exactly one instruction. With step mode off, the core runs freely and the pins pass the core's normal I/O data through. A separate capture register samples the bus and the low port-2 nibble on each rising edge of the address-latch-enable strobe. This keeps the I/O data observable even while the pins are showing the halt address.

The core is modelled by three inputs: a machine-cycle-done pulse, a two-cycle-instruction flag and the next-instruction address.

Top module: `step_halt_unit`

## Requirements
- R1: After reset the unit is not halted, `run` is 1, and both capture outputs are zero.
- R2: With `step_en` high, when an instruction's last machine cycle completes (`mc_done` with `run` high), `halted` is 1 from the next clock edge and `run` is 0 for as long as it stays halted.
- R3: When `mc_two` is 1, the first completed machine cycle of that instruction does not cause a halt. Only its second completed cycle ends the instruction.
- R4: While halted, `bus_out` equals bits 7..0 and `p2_out[3:0]` equals bits 11..8 of the `next_pc` value present in the cycle the halt was entered.
- R5: `p2_out[7:4]` always equals `p2_in[7:4]`, halted or not.
- R6: While not halted, `bus_out` equals `bus_in` and `p2_out[3:0]` equals `p2_in[3:0]`.
- R7: A rising edge on `step_req` releases the halted core for exactly one instruction, whether that instruction has one or two cycles. Holding `step_req` high releases no further instructions.
- R8: `step_req` passes through two synchronizer flops. `run` is 1 after the third clock edge that samples the request high.
- R9: With `step_en` low the unit never halts. Clearing `step_en` while halted sets `run` to 1 at the next edge.
- R10: On a clock edge where `ale` is 1 and was 0 at the previous edge, `cap_bus` takes `bus_in` and `cap_p2` takes `p2_in[3:0]`. At every other edge both hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | Step mode enable |
| step_req | input | 1 | Asynchronous step request |
| mc_done | input | 1 | Core completed a machine cycle this clock |
| mc_two | input | 1 | Current instruction takes two machine cycles |
| next_pc | input | 12 | Address of the next instruction to fetch |
| ale | input | 1 | Address-latch-enable strobe |
| bus_in | input | 8 | Core's normal data-bus value |
| p2_in | input | 8 | Core's normal port-2 value |
| run | output | 1 | Core may advance |
| halted | output | 1 | Unit is holding the core |
| bus_out | output | 8 | Data-bus pins |
| p2_out | output | 8 | Port-2 pins |
| cap_bus | output | 8 | Bus value captured on the strobe's rising edge |
| cap_p2 | output | 4 | Low port-2 nibble captured on the strobe's rising edge |

## Verification
A wrong cycle-position flag shows up on the first two-cycle instruction stepped. The halt then comes one cycle early, and the pins show an address one instruction behind in the same cycle that `halted` rises. A stale synchronizer or edge register shows up in two ways: `run` rises a cycle off the expected third edge, or the instruction count rises by more than one while the request is held. A capture register that is not edge-qualified drifts at the first bus change while the strobe is still high.

// File: rtl/step_halt_unit.sv
module step_halt_unit #(
  parameter int DW   = 8,
  parameter int AW   = 12,
  parameter int PW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic          step_req,
  input  logic          mc_done,
  input  logic          mc_two,
  input  logic [AW-1:0] next_pc,
  input  logic          ale,
  input  logic [DW-1:0] bus_in,
  input  logic [PW-1:0] p2_in,
  output logic          run,
  output logic          halted,
  output logic [DW-1:0] bus_out,
  output logic [PW-1:0] p2_out,
  output logic [DW-1:0] cap_bus,
  output logic [AW-DW-1:0] cap_p2
);
  localparam int HW = AW - DW;

  logic [SYNC:0]   req_sh;
  logic            step_pulse;
  logic            second;
  logic            instr_last;
  logic            halt_q;
  logic [AW-1:0]   addr_q;
  logic            ale_q;
  logic            ale_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) req_sh <= '0;
    else        req_sh <= {req_sh[SYNC-1:0], step_req};
  end
  assign step_pulse = req_sh[SYNC-1] & ~req_sh[SYNC];

  assign instr_last = mc_done & (~mc_two | second);

  always_ff @(posedge clk) begin
    if (!rst_n)              second <= 1'b0;
    else if (run && mc_done) second <= mc_two & ~second;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt_q <= 1'b0;
      addr_q <= '0;
    end else if (!step_en) begin
      halt_q <= 1'b0;
    end else if (halt_q) begin
      if (step_pulse) halt_q <= 1'b0;
    end else if (instr_last) begin
      halt_q <= 1'b1;
      addr_q <= next_pc;
    end
  end

  assign halted = halt_q;
  assign run    = ~halt_q;

  assign bus_out = halt_q ? addr_q[DW-1:0] : bus_in;

  generate
    if (PW > HW) begin : g_p2_hi
      assign p2_out[PW-1:HW] = p2_in[PW-1:HW];
    end
  endgenerate
  assign p2_out[HW-1:0] = halt_q ? addr_q[AW-1:DW] : p2_in[HW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ale_q   <= 1'b0;
      cap_bus <= '0;
      cap_p2  <= '0;
    end else begin
      ale_q <= ale;
      if (ale_rise) begin
        cap_bus <= bus_in;
        cap_p2  <= p2_in[HW-1:0];
      end
    end
  end
  assign ale_rise = ale & ~ale_q;

  a_r2_halt_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !halted && instr_last) |=> halted);
  a_r2_no_run_halted: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !run);
  a_r3_no_mid_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && mc_done && mc_two && !second) |=> !halted);
  a_r4_addr_shown: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> (bus_out == $past(next_pc[DW-1:0]) &&
                       p2_out[HW-1:0] == $past(next_pc[AW-1:DW])));
  a_r5_p2_high: assert property (@(posedge clk) disable iff (!rst_n)
    p2_out[PW-1:HW] == p2_in[PW-1:HW]);
  a_r7_stay_halted: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && step_en && !step_pulse) |=> halted);
  a_r9_free_run: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> !halted);
  a_r10_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && !ale_q) |=> (cap_bus == $past(bus_in)));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(ale && !ale_q) |=> $stable(cap_bus));
endmodule

// File: tb/tb_step_halt_unit.sv
module tb_step_halt_unit;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, step_en = 1'b0, step_req = 1'b0;
  logic mc_done = 1'b0, mc_two = 1'b0, ale = 1'b0;
  logic [11:0] next_pc = '0;
  logic [7:0] bus_in = '0, p2_in = '0;
  logic run, halted;
  logic [7:0] bus_out, p2_out, cap_bus;
  logic [3:0] cap_p2;

  int checks = 0, errors = 0;
  int pc = 0, phase = 0, icnt = 0;

  step_halt_unit dut (.*);

  function automatic logic two_of(int a);
    return (a % 3) == 1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (mc_done) begin
      if (mc_two && phase == 0) phase = 1;
      else begin phase = 0; pc = pc + 1; icnt++; end
    end
    mc_done = run;
    mc_two  = two_of(pc);
    next_pc = 12'(pc + 1);
    #1;
  endtask

  task automatic wait_halt();
    for (int i = 0; i < 20 && !halted; i++) tick();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; tick(); tick(); rst_n = 1'b1; tick();
    chk("R1 halted", halted, 0);
    chk("R1 run", run, 1);
    chk("R1 cap_bus", cap_bus, 0);
    chk("R1 cap_p2", cap_p2, 0);
  endtask

  task automatic t_free_run();
    int c0;
    step_en = 1'b0; bus_in = 8'h5A; p2_in = 8'hC3;
    c0 = icnt;
    for (int i = 0; i < 15; i++) begin
      tick();
      if (halted) chk("R9 no halt", halted, 0);
    end
    chk("R9 advanced", (icnt - c0) > 5, 1);
    chk("R6 bus pass", bus_out, 8'h5A);
    chk("R6 p2 pass", p2_out, 8'hC3);
  endtask

  task automatic t_enter_halt();
    step_en = 1'b1; p2_in = 8'hA7;
    wait_halt();
    chk("R2 halted", halted, 1);
    chk("R2 run low", run, 0);
    chk("R3 on boundary", phase, 0);
    chk("R4 bus addr", bus_out, pc[7:0]);
    chk("R4 p2 addr", p2_out[3:0], pc[11:8]);
    chk("R5 p2 high", p2_out[7:4], 4'hA);
  endtask

  task automatic t_step(input logic hold);
    int c0;
    logic two;
    c0 = icnt; two = two_of(pc);
    step_req = 1'b1;
    tick(); chk("R8 edge1", run, 0);
    tick(); chk("R8 edge2", run, 0);
    tick(); chk("R8 edge3", run, 1);
    if (!hold) step_req = 1'b0;
    if (two) begin tick(); chk("R3 mid", halted, 0); end
    wait_halt();
    for (int i = 0; i < 8; i++) tick();
    chk(two ? "R7 two-cycle one instr" : "R7 one instr", icnt - c0, 1);
    chk("R7 halted again", halted, 1);
    chk("R4 addr after step", {p2_out[3:0], bus_out}, pc[11:0]);
    step_req = 1'b0; tick(); tick(); tick();
  endtask

  task automatic t_leave();
    step_en = 1'b0; tick();
    chk("R9 resume", run, 1);
    bus_in = 8'h3C; #1;
    chk("R6 bus back", bus_out, 8'h3C);
  endtask

  task automatic t_capture();
    p2_in = 8'h9E; bus_in = 8'h11; ale = 1'b1; tick(); tick();
    chk("R10 cap bus", cap_bus, 8'h11);
    chk("R10 cap p2", cap_p2, 4'hE);
    bus_in = 8'h22; p2_in = 8'h94; tick();
    chk("R10 hold high", cap_bus, 8'h11);
    ale = 1'b0; tick(); tick();
    chk("R10 hold low", cap_bus, 8'h11);
    ale = 1'b1; tick(); tick();
    chk("R10 second edge", cap_p2, 4'h4);
    ale = 1'b0;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_free_run();
    t_enter_halt();
    for (int k = 0; k < 4; k++) t_step(1'b0);
    t_step(1'b1);
    t_step(1'b0);
    t_capture();
    t_leave();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule